// File: doc/BRIEF.md
# Multichannel Counter-Based Hit TDC

This block timestamps detector hits inside each beam crossing. A fine counter runs on a digitizing clock that is a fixed integer multiple of the beam-crossing clock. It steps through 2^BIN_W bins per crossing and wraps at the crossing boundary. Each of the NUM_CH discriminator inputs is synchronized and edge-detected. The first rising edge a channel sees in a crossing freezes that channel's copy of the count.

When a crossing ends, every channel's capture moves into a readout bank, and the capture stage starts the next crossing clean. The readout bank then holds each channel's word and a per-channel hit pattern for the whole of the following crossing, so readout and the trigger path overlap with new captures. A one-cycle frame strobe marks each update of the bank.

The block has two modes. Coarse mode reports the bin number. Fine mode also samples each input on the falling clock edge, which halves the bin. Coarse mode is the fallback for when the two edge paths cannot be trusted to line up.

Top module: `mc_hit_tdc`

## Requirements
- R1: Every channel captures on its own. Hits on several channels in one crossing each report their own value at word position ch*WORD_W (WORD_W = BIN_W+2), with no effect on other channels.
- R2: `frame_o` pulses high for exactly one cycle every 2^BIN_W clock cycles (64 with defaults). During the cycle in which it is high, the fine counter is at bin 0.
- R3: In coarse mode (`fine_en`=0), a rising input edge that arrives while the counter is at bin c is reported as code c+2. The 2 is the fixed synchronizer latency.
- R4: Only the first rising edge of a channel within a crossing is kept. Later edges in the same crossing do not change the reported code.
- R5: A channel with no captured hit in a crossing reports the all-ones code (0xFF with defaults) and a 0 in its `hit_pat_o` bit.
- R6: In fine mode (`fine_en`=1), an edge at bin c is reported as 2*(c+2) plus h. Here h=0 if the edge came in the first half of the clock period and h=1 if it came in the second half.
- R7: Bit ch of `hit_pat_o` is 1 exactly when channel ch has a captured hit in the crossing shown in the readout bank.
- R8: `tdc_word_o` and `hit_pat_o` change only on the clock edge that raises `frame_o`. They stay constant for the whole crossing while new hits are being captured.
- R9: A hit belongs to the crossing in which its synchronized edge is detected. An edge at bin 2^BIN_W-3 reports the last code (63) in the ending crossing. An edge at bin 2^BIN_W-2 reports code 0 in the next crossing.
- R10: While `rst_n` is low, every word is all-ones, `hit_pat_o` is 0 and `frame_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Digitizing clock, an integer multiple of the beam-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fine_en | input | 1 | 1 selects half-bin resolution, 0 selects single-edge coarse bins |
| disc_i | input | NUM_CH | Discriminator outputs, one per channel |
| tdc_word_o | output | NUM_CH*WORD_W | Readout bank of per-channel codes, channel ch at bits ch*WORD_W upward |
| hit_pat_o | output | NUM_CH | Per-crossing hit pattern for the trigger path |
| frame_o | output | 1 | One-cycle strobe when the readout bank takes a new crossing |

## Verification
The main tests are table-driven single hits. They cover low, middle and top bins, several channels, both modes and both half-periods, so an error in the latency offset, the doubling or the half bit shows up as a distinct wrong code. Directed patterns add the following cases. A pulse followed by a second edge separates first-hit capture from last-hit capture. Three channels hit in one crossing expose any crosstalk between channels. Hits at the last two bins show which crossing receives a hit detected on the wrap edge. A hit captured mid-crossing while the bank is sampled shows whether the bank is double-buffered or transparent.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic {
    TDC_COARSE = 1'b0,
    TDC_FINE   = 1'b1
  } tdc_mode_e;

  // Clock cycles from input edge (bin c) to capture (bin c + SYNC_LAT)
  localparam int unsigned TDC_SYNC_LAT = 2;
endpackage

// File: rtl/tdc_bin_counter.sv
module tdc_bin_counter #(
  parameter int BIN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [BIN_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [BIN_W-1:0] LAST_BIN = '1;

  logic [BIN_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LAST_BIN);
endmodule

// File: rtl/tdc_edge_sync.sv
module tdc_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic late_o
);
  logic p1_q, p2_q, p3_q;
  logic n1_q, n1r_q, n2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_q <= 1'b0;
      p2_q <= 1'b0;
      p3_q <= 1'b0;
    end else begin
      p1_q <= async_i;
      p2_q <= p1_q;
      p3_q <= p2_q;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) n1_q <= 1'b0;
    else        n1_q <= async_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n1r_q <= 1'b0;
      n2_q  <= 1'b0;
    end else begin
      n1r_q <= n1_q;
      n2_q  <= n1r_q;
    end
  end

  // Falling-edge path lagging the rising-edge path means a second-half arrival
  assign rise_o = p2_q & ~p3_q;
  assign late_o = ~n2_q;
endmodule

// File: rtl/tdc_chan_capture.sv
module tdc_chan_capture
  import tdc_pkg::*;
#(
  parameter int BIN_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tdc_mode_e          mode_i,
  input  logic [BIN_W-1:0]   cnt_i,
  input  logic               last_i,
  input  logic               rise_i,
  input  logic               late_i,
  output logic [BIN_W+1:0]   word_o,
  output logic               hit_o
);
  localparam int WORD_W = BIN_W + 2;
  localparam logic [WORD_W-1:0] EMPTY = '1;

  logic [WORD_W-1:0] code_now;
  logic              cap_vld_q, cap_vld_d;
  logic [WORD_W-1:0] cap_code_q, cap_code_d;
  logic              rd_hit_q, rd_hit_d;
  logic [WORD_W-1:0] rd_code_q, rd_code_d;
  logic              rd_en;

  always_comb begin
    if (mode_i == TDC_FINE) code_now = {1'b0, cnt_i, late_i};
    else                    code_now = {2'b00, cnt_i};
  end

  always_comb begin
    cap_vld_d  = cap_vld_q | rise_i;
    cap_code_d = (rise_i && !cap_vld_q) ? code_now : cap_code_q;
    rd_en      = last_i;
    rd_hit_d   = cap_vld_d;
    rd_code_d  = cap_vld_d ? cap_code_d : EMPTY;
    if (last_i) begin
      cap_vld_d  = 1'b0;
      cap_code_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld_q  <= 1'b0;
      cap_code_q <= '0;
    end else begin
      cap_vld_q  <= cap_vld_d;
      cap_code_q <= cap_code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hit_q  <= 1'b0;
      rd_code_q <= EMPTY;
    end else if (rd_en) begin
      rd_hit_q  <= rd_hit_d;
      rd_code_q <= rd_code_d;
    end
  end

  assign word_o = rd_code_q;
  assign hit_o  = rd_hit_q;
endmodule

// File: rtl/mc_hit_tdc.sv
module mc_hit_tdc
  import tdc_pkg::*;
#(
  parameter  int NUM_CH = 32,
  parameter  int BIN_W  = 6,
  localparam int WORD_W = BIN_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fine_en,
  input  logic [NUM_CH-1:0]        disc_i,
  output logic [NUM_CH*WORD_W-1:0] tdc_word_o,
  output logic [NUM_CH-1:0]        hit_pat_o,
  output logic                     frame_o
);
  logic       rs1_q, rs2_q;
  logic       rst_int_n;
  logic [BIN_W-1:0] cnt;
  logic       last;
  logic       frame_q;
  tdc_mode_e  mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_int_n = rs2_q;

  assign mode = tdc_mode_e'(fine_en);

  tdc_bin_counter #(.BIN_W(BIN_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cnt_o  (cnt),
    .last_o (last)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) frame_q <= 1'b0;
    else            frame_q <= last;
  end
  assign frame_o = frame_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic rise, late;

    tdc_edge_sync u_sync (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .async_i (disc_i[ch]),
      .rise_o  (rise),
      .late_o  (late)
    );

    tdc_chan_capture #(.BIN_W(BIN_W)) u_cap (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .mode_i (mode),
      .cnt_i  (cnt),
      .last_i (last),
      .rise_i (rise),
      .late_i (late),
      .word_o (tdc_word_o[ch*WORD_W +: WORD_W]),
      .hit_o  (hit_pat_o[ch])
    );
  end
endmodule

// File: rtl/tdc_chk.sv
module tdc_chk #(
  parameter int NUM_CH = 32,
  parameter int BIN_W  = 6
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           frame_i,
  input logic [NUM_CH*(BIN_W+2)-1:0]    words_i,
  input logic [NUM_CH-1:0]              hits_i
);
  localparam int WORD_W = BIN_W + 2;
  localparam int GAP_W  = BIN_W + 2;
  localparam logic [GAP_W-1:0] PERIOD_M1 = GAP_W'((1 << BIN_W) - 1);
  localparam logic [WORD_W-1:0] EMPTY = '1;

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (frame_i) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  // R2
  frame_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_i && seen_q) |-> (gap_q == PERIOD_M1));

  // R2
  frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i |=> !frame_i);

  // R8
  words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_i |-> $stable(words_i));

  // R8
  hits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_i |-> $stable(hits_i));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R5
    empty_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hits_i[ch] |-> (words_i[ch*WORD_W +: WORD_W] == EMPTY));

    // R7
    hit_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hits_i[ch] |-> (words_i[ch*WORD_W +: WORD_W] != EMPTY));
  end
endmodule

bind mc_hit_tdc tdc_chk #(.NUM_CH(NUM_CH), .BIN_W(BIN_W)) u_tdc_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .frame_i (frame_o),
  .words_i (tdc_word_o),
  .hits_i  (hit_pat_o)
);

// File: tb/mc_hit_tdc_bench.sv
module mc_hit_tdc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 32;
  localparam int BIN_W  = 6;
  localparam int WORD_W = BIN_W + 2;
  localparam int BINS   = 1 << BIN_W;
  localparam int EMPTY  = (1 << WORD_W) - 1;
  localparam int NV     = 8;

  // {channel[4:0], bin[5:0], second_half, fine}
  localparam logic [12:0] VEC [NV] = '{
    {5'd0,  6'd1,  1'b0, 1'b0},
    {5'd5,  6'd10, 1'b1, 1'b0},
    {5'd31, 6'd37, 1'b0, 1'b0},
    {5'd17, 6'd61, 1'b0, 1'b0},
    {5'd3,  6'd1,  1'b0, 1'b1},
    {5'd9,  6'd20, 1'b1, 1'b1},
    {5'd22, 6'd61, 1'b1, 1'b1},
    {5'd12, 6'd33, 1'b0, 1'b1}
  };

  logic                     clk;
  logic                     rst_n;
  logic                     fine_en;
  logic [NUM_CH-1:0]        disc;
  logic [NUM_CH*WORD_W-1:0] words;
  logic [NUM_CH-1:0]        hits;
  logic                     frame;

  int n_chk;
  int n_fail;
  bit done;

  mc_hit_tdc #(.NUM_CH(NUM_CH), .BIN_W(BIN_W)) u_mc_hit_tdc (
    .clk        (clk),
    .rst_n      (rst_n),
    .fine_en    (fine_en),
    .disc_i     (disc),
    .tdc_word_o (words),
    .hit_pat_o  (hits),
    .frame_o    (frame)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_code(int bin, bit half, bit fine);
    int d = bin + 2;
    return fine ? (2 * d + int'(half)) : d;
  endfunction

  function automatic int word_of(int ch);
    return int'(words[ch*WORD_W +: WORD_W]);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Returns at the falling edge inside bin 0 of a crossing
  task automatic wait_frame();
    @(negedge clk);
    while (!frame) @(negedge clk);
  endtask

  // From a wait_frame anchor, raise a channel in bin c (c >= 1)
  task automatic hit_at(int ch, int bin, bit half);
    repeat (bin) @(posedge clk);
    if (half) #6; else #1;
    disc[ch] = 1'b1;
  endtask

  task automatic check_others(string req, int ch_a, int ch_b, int ch_c);
    int bad = 0;
    for (int i = 0; i < NUM_CH; i++)
      if (i != ch_a && i != ch_b && i != ch_c && word_of(i) != EMPTY) bad++;
    check(req, bad, 0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R2 actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    logic [NUM_CH-1:0] pat;
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; fine_en = 1'b0; disc = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 words", (words == '1) ? 1 : 0, 1);
    check("R10 hit_pat", int'(hits), 0);
    check("R10 frame", int'(frame), 0);
    rst_n = 1'b1;

    // R2 frame period
    begin
      int n = 0;
      wait_frame();
      do begin @(negedge clk); n++; end while (!frame);
      check("R2 period", n, BINS);
    end

    // R3 R6 R9 table of single hits
    for (int v = 0; v < NV; v++) begin
      int ch  = int'(VEC[v][12:8]);
      int bin = int'(VEC[v][7:2]);
      bit hf  = VEC[v][1];
      bit fn  = VEC[v][0];
      fine_en = fn;
      wait_frame();
      hit_at(ch, bin, hf);
      wait_frame();
      check(fn ? "R6 fine code" : "R3 coarse code", word_of(ch), exp_code(bin, hf, fn));
      check("R7 pattern", int'(hits), int'(1 << ch));
      disc = '0;
    end
    fine_en = 1'b0;

    // R4 first hit only, then R5 empty crossing
    wait_frame();
    hit_at(7, 5, 1'b0);
    repeat (3) @(posedge clk);
    #1 disc[7] = 1'b0;
    repeat (22) @(posedge clk);
    #1 disc[7] = 1'b1;
    wait_frame();
    check("R4 first hit kept", word_of(7), 7);
    disc = '0;
    wait_frame();
    check("R5 empty code", word_of(7), EMPTY);
    check("R5 empty pattern", int'(hits), 0);

    // R1 independent channels in one crossing
    wait_frame();
    hit_at(0, 2, 1'b0);
    hit_at(1, 1, 1'b0);
    hit_at(31, 37, 1'b0);
    wait_frame();
    check("R1 ch0", word_of(0), 4);
    check("R1 ch1", word_of(1), 5);
    check("R1 ch31", word_of(31), 42);
    check_others("R1 others empty", 0, 1, 31);
    pat = 32'h8000_0003;
    check("R7 multi pattern", int'(hits), int'(pat));

    // R8 bank holds while next crossing captures
    hit_at(10, 30, 1'b0);
    repeat (5) @(negedge clk);
    check("R8 word held", word_of(0), 4);
    check("R8 pattern held", int'(hits), int'(pat));
    wait_frame();
    check("R8 new capture", word_of(10), 32);
    check("R8 no re-rise ch0", word_of(0), EMPTY);
    disc = '0;

    // R9 wrap boundary
    wait_frame();
    hit_at(4, 62, 1'b0);
    wait_frame();
    check("R9 not in ending crossing", int'(hits[4]), 0);
    wait_frame();
    check("R9 next crossing code", word_of(4), 0);
    check("R9 next crossing hit", int'(hits[4]), 1);
    disc = '0;

    done = 1;
    summary();
  end
endmodule